// File: doc/BRIEF.md
# Resistive Touch Panel Scan Sequencer

This block sequences a four-wire resistive touch panel front end. Each scan it steers the plates for an X reading, a Y reading and a pressure reading, in that order. For each reading it writes the 16-bit panel control word and starts one conversion on an attached ADC. It captures each result when the ADC signals completion. After the third reading it switches the ADC off and puts the panel back into pen-detect mode. It then waits a fixed interval and samples the two pen-level flags from the panel readback.

When the pen is still down, the block emits one sample strobe carrying X, Y and pressure, and schedules the next scan one wait interval later. When the pen is up, it pulses a re-arm request for the pen interrupt. If the last check produced a sample, it also emits exactly one release strobe. It then sleeps until a pen interrupt or a restart arrives. Dropping the enable input ends scanning: any outstanding sample is released, and the panel control word is cleared.

Each position reading writes its plate setup twice in pressure mode before it switches to position mode. It then waits a settle time before converting. All delays are given in microseconds and turned into clock counts through a clocks-per-microsecond parameter.

Top module: `tsc_scan_seq`

## Requirements
- R1: Out of reset, and while enable is low, no panel write, conversion start or strobe occurs. The first panel write of a scan comes in the cycle after enable is first seen high.
- R2: The X reading writes 0x0912 on two consecutive cycles and then 0x0A12. The conversion start, with channel 2, comes SETTLE_US*CLK_PER_US+1 cycles after the third write. The control word is laid out as follows: bits 3:0 power plates MX/PX/MY/PY, bits 7:4 ground the same plates in the same order, bits 9:8 hold the mode (0 detect, 1 pressure, 2 position), and bit 11 enables bias.
- R3: The Y reading starts one cycle after the X conversion completes. It writes 0x0948 twice and then 0x0A48 on consecutive cycles. Its conversion start, with channel 0, follows the same settle rule as R2.
- R4: The pressure reading writes 0x09C3 one cycle after the Y conversion completes. Its conversion start, with channel 2, follows PRES_US*CLK_PER_US+1 cycles after that write.
- R5: adc_en is high from the first X write through the last conversion. Each result is taken from adc_data in the cycle adc_done is high.
- R6: One cycle after the pressure conversion completes, the block writes 0x00C3 with adc_en low. The pen check falls WAIT_US*CLK_PER_US+1 cycles after that write.
- R7: When both pen_lvl bits are 0 at the check, smp_vld pulses for one cycle with the three captured results. The next scan's first write comes WAIT_US*CLK_PER_US+1 cycles later.
- R8: When either pen_lvl bit is 1 at the check, irq_arm pulses and no sample is emitted. rel_vld pulses in the same cycle only if the previous check emitted a sample. The block then issues no writes until woken.
- R9: A pen_irq pulse while sleeping starts a scan with its first write in the next cycle. A pen_irq pulse at any other time has no effect on the write timing.
- R10: A restart pulse while enabled and not shutting down aborts any reading in progress. The next cycle begins a new scan at the first X write.
- R11: Deasserting enable causes the following, after which the block issues nothing further: in the next cycle, rel_vld if a sample is outstanding; in the cycle after that, a panel write of 0x0000.
- R12: smp_vld, rel_vld, adc_start and irq_arm are single-cycle pulses. smp_vld and rel_vld are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Scanning enabled |
| pen_irq | input | 1 | Pen interrupt pulse |
| restart | input | 1 | Request a fresh scan cycle |
| adc_done | input | 1 | Conversion complete, data valid |
| adc_data | input | ADC_W | Conversion result |
| pen_lvl | input | 2 | Panel readback pen flags: bit 0 PX-low, bit 1 MX-low |
| panel_we | output | 1 | Panel control write strobe |
| panel_wdata | output | 16 | Panel control word |
| adc_en | output | 1 | ADC powered |
| adc_start | output | 1 | Start one conversion |
| adc_chan | output | 2 | Channel: 0 PX, 1 MX, 2 PY, 3 MY |
| smp_vld | output | 1 | Sample strobe |
| smp_x | output | ADC_W | X result |
| smp_y | output | ADC_W | Y result |
| smp_p | output | ADC_W | Pressure result |
| rel_vld | output | 1 | Release strobe |
| irq_arm | output | 1 | Re-arm the pen interrupt |

## Verification
The bench builds the block with CLK_PER_US=2, SETTLE_US=3, PRES_US=1 and WAIT_US=5. That gives a 6-cycle settle, a 2-cycle pressure delay and a 10-cycle wait. Complete scans, sleeps and wake-ups therefore take tens of cycles, and every gap can be checked to the exact cycle. The nonzero pressure delay exercises the delay counter on every reading. The short wait leaves room to inject pen interrupts, restarts and a disable inside the post-sample interval.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int PW = 16;

  localparam logic [3:0] PL_MX = 4'b0001;
  localparam logic [3:0] PL_PX = 4'b0010;
  localparam logic [3:0] PL_MY = 4'b0100;
  localparam logic [3:0] PL_PY = 4'b1000;

  localparam logic [1:0] MODE_DET = 2'd0;
  localparam logic [1:0] MODE_PRS = 2'd1;
  localparam logic [1:0] MODE_POS = 2'd2;

  localparam logic [1:0] CH_PX = 2'd0;
  localparam logic [1:0] CH_PY = 2'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_X1, S_X2, S_X3, S_XSET, S_XGO, S_XWAIT,
    S_Y1, S_Y2, S_Y3, S_YSET, S_YGO, S_YWAIT,
    S_P1, S_PDLY, S_PGO, S_PWAIT,
    S_INT, S_PENW, S_CHK, S_NEXT, S_SLEEP, S_OFFR, S_OFFW
  } state_t;

  // Panel control word: power plates, ground plates, mode, bias.
  function automatic logic [PW-1:0] panel_word(input logic [3:0] pwr,
                                               input logic [3:0] gnd,
                                               input logic [1:0] mode,
                                               input logic       bias);
    return {4'b0000, bias, 1'b0, mode, gnd, pwr};
  endfunction

  function automatic logic pen_is_up(input logic [1:0] lvl);
    return lvl[0] | lvl[1];
  endfunction

  function automatic int us_to_cyc(input int us, input int cpu);
    return us * cpu;
  endfunction

  function automatic logic is_running(input state_t s);
    return (s != S_IDLE) && (s != S_OFFR) && (s != S_OFFW);
  endfunction

endpackage

// File: rtl/tsc_dly_timer.sv
module tsc_dly_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/tsc_sample_hold.sv
module tsc_sample_hold #(
  parameter int ADC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cap,
  input  logic [ADC_W-1:0] din,
  output logic [ADC_W-1:0] x,
  output logic [ADC_W-1:0] y,
  output logic [ADC_W-1:0] p
);
  logic [ADC_W-1:0] hold [3];

  for (genvar i = 0; i < 3; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)      hold[i] <= '0;
      else if (cap[i]) hold[i] <= din;
    end
  end

  assign x = hold[0];
  assign y = hold[1];
  assign p = hold[2];
endmodule

// File: rtl/tsc_scan_seq.sv
module tsc_scan_seq import tsc_pkg::*; #(
  parameter int CLK_PER_US = 50,
  parameter int SETTLE_US  = 55,
  parameter int PRES_US    = 0,
  parameter int WAIT_US    = 10000,
  parameter int ADC_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pen_irq,
  input  logic             restart,
  input  logic             adc_done,
  input  logic [ADC_W-1:0] adc_data,
  input  logic [1:0]       pen_lvl,
  output logic             panel_we,
  output logic [PW-1:0]    panel_wdata,
  output logic             adc_en,
  output logic             adc_start,
  output logic [1:0]       adc_chan,
  output logic             smp_vld,
  output logic [ADC_W-1:0] smp_x,
  output logic [ADC_W-1:0] smp_y,
  output logic [ADC_W-1:0] smp_p,
  output logic             rel_vld,
  output logic             irq_arm
);
  localparam int SET_CYC  = us_to_cyc(SETTLE_US, CLK_PER_US);
  localparam int PRS_CYC  = us_to_cyc(PRES_US, CLK_PER_US);
  localparam int WAIT_CYC = us_to_cyc(WAIT_US, CLK_PER_US);
  localparam int MAX_AB   = (SET_CYC > PRS_CYC) ? SET_CYC : PRS_CYC;
  localparam int MAX_CYC  = (WAIT_CYC > MAX_AB) ? WAIT_CYC : MAX_AB;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SET_LD  = CNT_W'((SET_CYC  > 0) ? SET_CYC  - 1 : 0);
  localparam logic [CNT_W-1:0] PRS_LD  = CNT_W'((PRS_CYC  > 0) ? PRS_CYC  - 1 : 0);
  localparam logic [CNT_W-1:0] WAIT_LD = CNT_W'((WAIT_CYC > 0) ? WAIT_CYC - 1 : 0);

  state_t st, nxt;
  logic   tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic   valid_q;

  // Named internal events for the checker.
  logic ev_pen_chk, ev_pen_up, ev_cap_x, ev_cap_y, ev_cap_p;

  assign ev_pen_chk = (st == S_CHK) && enable;
  assign ev_pen_up  = pen_is_up(pen_lvl);
  assign ev_cap_x   = (st == S_XWAIT) && adc_done;
  assign ev_cap_y   = (st == S_YWAIT) && adc_done;
  assign ev_cap_p   = (st == S_PWAIT) && adc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    nxt = st;
    if (is_running(st) && !enable) begin
      nxt = S_OFFR;
    end else if (is_running(st) && restart) begin
      nxt = S_X1;
    end else begin
      case (st)
        S_IDLE:  if (enable) nxt = S_X1;
        S_X1:    nxt = S_X2;
        S_X2:    nxt = S_X3;
        S_X3:    nxt = (SET_CYC == 0) ? S_XGO : S_XSET;
        S_XSET:  if (tmr_zero) nxt = S_XGO;
        S_XGO:   nxt = S_XWAIT;
        S_XWAIT: if (adc_done) nxt = S_Y1;
        S_Y1:    nxt = S_Y2;
        S_Y2:    nxt = S_Y3;
        S_Y3:    nxt = (SET_CYC == 0) ? S_YGO : S_YSET;
        S_YSET:  if (tmr_zero) nxt = S_YGO;
        S_YGO:   nxt = S_YWAIT;
        S_YWAIT: if (adc_done) nxt = S_P1;
        S_P1:    nxt = (PRS_CYC == 0) ? S_PGO : S_PDLY;
        S_PDLY:  if (tmr_zero) nxt = S_PGO;
        S_PGO:   nxt = S_PWAIT;
        S_PWAIT: if (adc_done) nxt = S_INT;
        S_INT:   nxt = S_PENW;
        S_PENW:  if (tmr_zero) nxt = S_CHK;
        S_CHK:   nxt = ev_pen_up ? S_SLEEP : S_NEXT;
        S_NEXT:  if (tmr_zero) nxt = S_X1;
        S_SLEEP: if (pen_irq) nxt = S_X1;
        S_OFFR:  nxt = S_OFFW;
        S_OFFW:  nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  // Load the shared timer on entry into any delay state.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (nxt != st) begin
      case (nxt)
        S_XSET, S_YSET: begin tmr_load = 1'b1; tmr_val = SET_LD;  end
        S_PDLY:         begin tmr_load = 1'b1; tmr_val = PRS_LD;  end
        S_PENW, S_NEXT: begin tmr_load = 1'b1; tmr_val = WAIT_LD; end
        default: ;
      endcase
    end
  end

  tsc_dly_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  tsc_sample_hold #(.ADC_W(ADC_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap({ev_cap_p, ev_cap_y, ev_cap_x}),
    .din(adc_data), .x(smp_x), .y(smp_y), .p(smp_p)
  );

  always_comb begin
    panel_we    = 1'b1;
    panel_wdata = '0;
    case (st)
      S_X1, S_X2: panel_wdata = panel_word(PL_PX, PL_MX, MODE_PRS, 1'b1);
      S_X3:       panel_wdata = panel_word(PL_PX, PL_MX, MODE_POS, 1'b1);
      S_Y1, S_Y2: panel_wdata = panel_word(PL_PY, PL_MY, MODE_PRS, 1'b1);
      S_Y3:       panel_wdata = panel_word(PL_PY, PL_MY, MODE_POS, 1'b1);
      S_P1:       panel_wdata = panel_word(PL_PX | PL_MX, PL_PY | PL_MY, MODE_PRS, 1'b1);
      S_INT:      panel_wdata = panel_word(PL_PX | PL_MX, PL_PY | PL_MY, MODE_DET, 1'b0);
      S_OFFW:     panel_wdata = '0;
      default:    panel_we    = 1'b0;
    endcase
  end

  always_comb begin
    adc_chan = CH_PX;
    case (st)
      S_XGO, S_XWAIT, S_PGO, S_PWAIT: adc_chan = CH_PY;
      default:                        adc_chan = CH_PX;
    endcase
  end

  assign adc_en    = (st >= S_X1) && (st <= S_PWAIT);
  assign adc_start = (st == S_XGO) || (st == S_YGO) || (st == S_PGO);
  assign smp_vld   = ev_pen_chk && !ev_pen_up;
  assign irq_arm   = ev_pen_chk && ev_pen_up;
  assign rel_vld   = valid_q && ((ev_pen_chk && ev_pen_up) || (st == S_OFFR));

  always_ff @(posedge clk) begin
    if (!rst_n)       valid_q <= 1'b0;
    else if (smp_vld) valid_q <= 1'b1;
    else if (rel_vld) valid_q <= 1'b0;
  end
endmodule

// File: rtl/tsc_scan_seq_chk.sv
module tsc_scan_seq_chk import tsc_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          panel_we,
  input logic [PW-1:0] panel_wdata,
  input logic          adc_en,
  input logic          adc_start,
  input logic          smp_vld,
  input logic          rel_vld,
  input logic          irq_arm,
  input logic          ev_pen_chk
);
  logic smp_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)       smp_seen <= 1'b0;
    else if (smp_vld) smp_seen <= 1'b1;
    else if (rel_vld) smp_seen <= 1'b0;
  end

  a_r12_smp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> !smp_vld);
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r12_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && rel_vld));
  a_r5_start_powered: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> adc_en);
  a_r6_detect_adc_off: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_we && panel_wdata == 16'h00C3) |-> !adc_en);
  a_r2_pos_after_pres: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_we && panel_wdata == 16'h0A12) |-> $past(panel_we && panel_wdata == 16'h0912));
  a_r8_rel_needs_smp: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld |-> smp_seen);
  a_r8_arm_only_at_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_arm |-> (ev_pen_chk && !smp_vld));
  a_r11_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_vld && !enable) |=> (panel_we && panel_wdata == 16'h0000));
endmodule

bind tsc_scan_seq tsc_scan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .panel_we(panel_we),
  .panel_wdata(panel_wdata), .adc_en(adc_en), .adc_start(adc_start),
  .smp_vld(smp_vld), .rel_vld(rel_vld), .irq_arm(irq_arm),
  .ev_pen_chk(ev_pen_chk)
);

// File: tb/tsc_scan_seq_test.sv
module tsc_scan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2, SET_US = 3, PRS_US = 1, WT_US = 5, AW = 10;
  localparam int N  = CPU * SET_US;
  localparam int NP = CPU * PRS_US;
  localparam int W  = CPU * WT_US;
  localparam int L  = 3;
  localparam int K_SMP = 0, K_REL = 1, K_ARM = 2;

  logic clk = 0, rst_n = 0, enable = 0, pen_irq = 0, restart = 0, adc_done = 0;
  logic [AW-1:0] adc_data = '0;
  logic [1:0] pen_lvl = 2'b00;
  logic panel_we, adc_en, adc_start, smp_vld, rel_vld, irq_arm;
  logic [15:0] panel_wdata;
  logic [1:0] adc_chan;
  logic [AW-1:0] smp_x, smp_y, smp_p;

  int n_run = 0, n_fail = 0, cyc = 0, due = -1, conv_k = 0, n_double = 0;
  int wq_c[$], wq_d[$], wq_e[$], sq_c[$], sq_ch[$], dq[$];
  int smp_c[$], smp_xq[$], smp_yq[$], smp_pq[$], rel_c[$], arm_c[$];
  logic prev_smp = 0, prev_rel = 0, prev_st = 0, prev_arm = 0;

  tsc_scan_seq #(.CLK_PER_US(CPU), .SETTLE_US(SET_US), .PRES_US(PRS_US),
                 .WAIT_US(WT_US), .ADC_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pen_irq(pen_irq), .restart(restart),
    .adc_done(adc_done), .adc_data(adc_data), .pen_lvl(pen_lvl),
    .panel_we(panel_we), .panel_wdata(panel_wdata), .adc_en(adc_en),
    .adc_start(adc_start), .adc_chan(adc_chan), .smp_vld(smp_vld),
    .smp_x(smp_x), .smp_y(smp_y), .smp_p(smp_p), .rel_vld(rel_vld), .irq_arm(irq_arm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int popq(ref int q[$]);
    if (q.size() == 0) return -1;
    return q.pop_front();
  endfunction

  // Event recorder, sampled mid-cycle.
  always @(negedge clk) begin
    if (rst_n) begin
      if (panel_we) begin wq_c.push_back(cyc); wq_d.push_back(int'(panel_wdata)); wq_e.push_back(int'(adc_en)); end
      if (adc_start) begin sq_c.push_back(cyc); sq_ch.push_back(int'(adc_chan)); due = cyc + L; end
      if (smp_vld) begin smp_c.push_back(cyc); smp_xq.push_back(int'(smp_x));
                         smp_yq.push_back(int'(smp_y)); smp_pq.push_back(int'(smp_p)); end
      if (rel_vld) rel_c.push_back(cyc);
      if (irq_arm) arm_c.push_back(cyc);
      if ((smp_vld && prev_smp) || (rel_vld && prev_rel) || (adc_start && prev_st) ||
          (irq_arm && prev_arm) || (smp_vld && rel_vld)) n_double++;
      prev_smp = smp_vld; prev_rel = rel_vld; prev_st = adc_start; prev_arm = irq_arm;
    end
  end

  // ADC model: result L cycles after each start.
  always @(posedge clk) begin
    #1;
    adc_done = 0;
    if (cyc == due) begin
      adc_done = 1;
      adc_data = AW'((37 * conv_k + 5) % 1024);
      dq.push_back((37 * conv_k + 5) % 1024);
      conv_k++;
    end
  end

  always @(posedge clk) begin
    if (cyc == 30000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic step(output int c);
    @(posedge clk); #1; c = cyc;
  endtask

  task automatic pulse_pen(output int c);
    step(c); pen_irq = 1; @(posedge clk); #1; pen_irq = 0;
  endtask

  task automatic pulse_restart(output int c);
    step(c); restart = 1; @(posedge clk); #1; restart = 0;
  endtask

  task automatic verify_scan(input int first_exp, input string ftag, input int kind, output int tchk);
    int wc[8], wd[8], we_[8], sc[3], sch[3], dv[3];
    while (wq_c.size() < 8 || sq_c.size() < 3 || dq.size() < 3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin wc[i] = popq(wq_c); wd[i] = popq(wq_d); we_[i] = popq(wq_e); end
    for (int i = 0; i < 3; i++) begin sc[i] = popq(sq_c); sch[i] = popq(sq_ch); dv[i] = popq(dq); end
    if (first_exp >= 0) eq(ftag, wc[0], first_exp);
    eq("R2 x write 1", wd[0], 16'h0912);
    eq("R2 x write 2", wd[1], 16'h0912);
    eq("R2 x write 3", wd[2], 16'h0A12);
    eq("R2 x writes back to back", wc[2] - wc[0], 2);
    eq("R2 x settle gap", sc[0] - wc[2], N + 1);
    eq("R2 x channel", sch[0], 2);
    eq("R5 adc on at first write", we_[0], 1);
    eq("R3 y start after x done", wc[3] - sc[0], L + 1);
    eq("R3 y write 1", wd[3], 16'h0948);
    eq("R3 y write 2", wd[4], 16'h0948);
    eq("R3 y write 3", wd[5], 16'h0A48);
    eq("R3 y writes back to back", wc[5] - wc[3], 2);
    eq("R3 y settle gap", sc[1] - wc[5], N + 1);
    eq("R3 y channel", sch[1], 0);
    eq("R4 pressure word", wd[6], 16'h09C3);
    eq("R4 pressure after y done", wc[6] - sc[1], L + 1);
    eq("R4 pressure delay gap", sc[2] - wc[6], NP + 1);
    eq("R4 pressure channel", sch[2], 2);
    eq("R6 detect word", wd[7], 16'h00C3);
    eq("R6 detect after p done", wc[7] - sc[2], L + 1);
    eq("R6 adc off at detect write", we_[7], 0);
    tchk = wc[7] + W + 1;
    while (cyc <= tchk + 1) @(negedge clk);
    if (kind == K_SMP) begin
      eq("R7 sample cycle", popq(smp_c), tchk);
      eq("R5 x value", popq(smp_xq), dv[0]);
      eq("R5 y value", popq(smp_yq), dv[1]);
      eq("R5 p value", popq(smp_pq), dv[2]);
      eq("R7 no release", rel_c.size(), 0);
      eq("R7 no arm", arm_c.size(), 0);
    end else begin
      eq("R8 arm cycle", popq(arm_c), tchk);
      eq("R8 no sample", smp_c.size(), 0);
      if (kind == K_REL) eq("R8 release cycle", popq(rel_c), tchk);
      else               eq("R8 no release", rel_c.size(), 0);
    end
  endtask

  initial begin
    int c, t, n0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    eq("R1 reset strobes", int'({panel_we, adc_en, adc_start, smp_vld, rel_vld, irq_arm}), 0);
    repeat (20) @(posedge clk);
    eq("R1 idle while disabled", wq_c.size() + sq_c.size(), 0);

    step(c); enable = 1;
    verify_scan(c + 1, "R1 first write after enable", K_SMP, t);

    pen_lvl = 2'b01;
    verify_scan(t + W + 1, "R7 next scan timing", K_REL, t);

    repeat (60) @(posedge clk);
    @(negedge clk);
    eq("R8 asleep no writes", wq_c.size() + sq_c.size(), 0);

    pen_lvl = 2'b10;
    pulse_pen(c);
    verify_scan(c + 1, "R9 wake on pen irq", K_ARM, t);

    pen_lvl = 2'b00;
    pulse_restart(c);
    verify_scan(c + 1, "R10 wake on restart", K_SMP, t);

    pulse_pen(c);
    verify_scan(t + W + 1, "R9 pen irq ignored in wait", K_SMP, t);

    while (wq_c.size() < 3) @(negedge clk);
    pulse_restart(c);
    @(negedge clk);
    eq("R10 no conversion before abort", sq_c.size(), 0);
    for (int i = 0; i < 3; i++) begin n0 = popq(wq_c); n0 = popq(wq_d); n0 = popq(wq_e); end
    verify_scan(c + 1, "R10 abort restarts scan", K_SMP, t);

    while (cyc < t + 3) @(posedge clk);
    #1; c = cyc; enable = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    eq("R11 release after disable", popq(rel_c), c + 1);
    eq("R11 clear write cycle", popq(wq_c), c + 2);
    eq("R11 clear write value", popq(wq_d), 0);
    n0 = popq(wq_e);
    repeat (40) @(posedge clk);
    @(negedge clk);
    eq("R11 silent when off", wq_c.size() + sq_c.size() + arm_c.size(), 0);

    pen_lvl = 2'b01;
    step(c); enable = 1;
    verify_scan(c + 1, "R11 re-enable scan", K_ARM, t);

    eq("R12 single-cycle strobes", n_double, 0);
    eq("R12 no stray events", smp_c.size() + rel_c.size() + arm_c.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule